// File: doc/BRIEF.md
# Shift-Based Triplet Coincidence Finder

This block searches for straight tracks that cross three detector planes. Hits arrive one per clock as a coordinate and a plane code, in no particular order. During the fill phase, hits on the two outer planes (A and C) set bits in two N-bit occupancy arrays. The C array is stored mirrored. During the match phase, each centre-plane (B) hit of coordinate b drives one barrel shifter that moves both arrays. The A array is shifted by b and the mirrored C array by the bitwise complement of b. After the shift, a pair of hits a and c with a + c = 2b sits at the same bit position.

Only 2W+1 positions around the centre are ANDed, which limits the accepted track slope to |a - b| <= W. The same AND gates and encoder serve every centre hit. An event costs one clock per outer hit plus one clock per centre hit, and the shifter pipeline accepts a new centre hit every cycle. A clear input empties both arrays in one cycle and returns the block to the fill phase.

Top module: `triplet_shift_finder`

## Requirements
- R1: After reset, trip_valid and err_hit are 0, both arrays are empty and the block is in the fill phase.
- R2: In the fill phase, a hit with plane code 0 sets A bit coord and a hit with plane code 2 records C coordinate coord. Hits with plane code 1 or 3 have no effect on either array and produce no output.
- R3: In the match phase, a hit with plane code 1 and coordinate b produces trip_valid = 1 exactly when some stored A coordinate a and C coordinate c satisfy a + c = 2b with |a - b| <= W.
- R4: When several pairs qualify, trip_pos is the smallest qualifying A coordinate a, and trip_centre equals b.
- R5: A centre hit sampled at clock edge t has its result on the outputs from edge t + log2(N) until the next edge. Centre hits may be presented on consecutive cycles, and each gets its own result.
- R6: start_match enters the match phase and freezes both arrays. A plane-0 or plane-2 hit in the match phase leaves the arrays unchanged and sets err_hit for the one cycle after it is sampled.
- R7: clear empties both arrays in one cycle and returns the block to the fill phase. It takes priority over start_match and over any hit in the same cycle, so that hit is neither stored, matched nor flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_valid | input | 1 | A hit is presented this cycle |
| plane | input | 2 | Plane code: 0 = A, 1 = B (centre), 2 = C, 3 = unused |
| coord | input | log2(N) | Hit coordinate |
| start_match | input | 1 | Enter the match phase |
| clear | input | 1 | Empty both arrays and return to the fill phase |
| trip_valid | output | 1 | A triplet was found for the centre hit |
| trip_centre | output | log2(N) | Centre coordinate b of that hit |
| trip_pos | output | log2(N) | Lowest qualifying A coordinate |
| err_hit | output | 1 | An outer-plane hit arrived during the match phase |

## Verification
The hardest condition to reach is a full run of back-to-back centre hits. In that run, every pipeline stage carries a different shift amount at once, and a wrong stage ordering or a wrong complement on the C side moves only some results. The bench therefore drives all N centre coordinates on consecutive cycles for every event. It checks each result at its own cycle against a brute-force search over the loaded masks. The events are pseudo-random masks, empty and full arrays, and hand-placed pairs that sit exactly at and just past the slope window edge.

// File: rtl/triplet_shift_finder.sv
module triplet_shift_finder #(
  parameter int N = 16,
  parameter int W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit_valid,
  input  logic [1:0]           plane,
  input  logic [$clog2(N)-1:0] coord,
  input  logic                 start_match,
  input  logic                 clear,
  output logic                 trip_valid,
  output logic [$clog2(N)-1:0] trip_centre,
  output logic [$clog2(N)-1:0] trip_pos,
  output logic                 err_hit
);
  localparam int LN  = $clog2(N);
  localparam int EW  = N + W;
  localparam int WIN = 2 * W + 1;
  localparam logic [1:0] PL_A = 2'd0;
  localparam logic [1:0] PL_B = 2'd1;
  localparam logic [1:0] PL_C = 2'd2;

  logic [N-1:0] arr_a, arr_c;
  logic         match_mode;

  wire is_outer  = hit_valid && (plane == PL_A || plane == PL_C);
  wire centre_go = hit_valid && (plane == PL_B) && match_mode && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_a      <= '0;
      arr_c      <= '0;
      match_mode <= 1'b0;
      err_hit    <= 1'b0;
    end else begin
      err_hit <= match_mode && !clear && is_outer;
      if (clear) begin
        arr_a      <= '0;
        arr_c      <= '0;
        match_mode <= 1'b0;
      end else begin
        if (start_match) match_mode <= 1'b1;
        if (!match_mode && hit_valid) begin
          if (plane == PL_A) arr_a[coord]  <= 1'b1;
          if (plane == PL_C) arr_c[~coord] <= 1'b1;
        end
      end
    end
  end

  wire [EW-1:0] ext_a = {arr_a, {W{1'b0}}};
  wire [EW-1:0] ext_c = {arr_c, {W{1'b0}}};

  logic [EW-1:0] pa [LN];
  logic [EW-1:0] pc [LN];
  logic [LN-1:0] pb [LN];
  logic [LN-1:0] pv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
      for (int s = 0; s < LN; s++) begin
        pa[s] <= '0;
        pc[s] <= '0;
        pb[s] <= '0;
      end
    end else begin
      pv[0] <= centre_go;
      pb[0] <= coord;
      pa[0] <= coord[0] ? (ext_a >> 1) : ext_a;
      pc[0] <= coord[0] ? ext_c : (ext_c >> 1);
      for (int s = 1; s < LN; s++) begin
        pv[s] <= pv[s-1];
        pb[s] <= pb[s-1];
        pa[s] <= pb[s-1][s] ? (pa[s-1] >> (1 << s)) : pa[s-1];
        pc[s] <= pb[s-1][s] ? pc[s-1] : (pc[s-1] >> (1 << s));
      end
    end
  end

  wire [WIN-1:0] coinc = pa[LN-1][WIN-1:0] & pc[LN-1][WIN-1:0];
  logic          found;
  logic [LN-1:0] first_idx;

  always_comb begin
    found     = 1'b0;
    first_idx = '0;
    for (int i = WIN - 1; i >= 0; i--) begin
      if (coinc[i]) begin
        found     = 1'b1;
        first_idx = LN'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_valid  <= 1'b0;
      trip_centre <= '0;
      trip_pos    <= '0;
    end else begin
      trip_valid  <= pv[LN-1] && found;
      trip_centre <= pb[LN-1];
      trip_pos    <= pb[LN-1] + first_idx - LN'(W);
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (arr_a == '0 && arr_c == '0)); // R7
  AST_CLEAR_TO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !match_mode); // R7
  AST_START_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start_match && !clear) |=> match_mode); // R6
  AST_FROZEN_IN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (match_mode && !clear) |=> ($stable(arr_a) && $stable(arr_c))); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |-> $past(match_mode && is_outer)); // R6
  AST_POS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    trip_valid |-> (({1'b0, trip_pos} + (LN+1)'(W) >= {1'b0, trip_centre}) &&
                    ({1'b0, trip_pos} <= {1'b0, trip_centre} + (LN+1)'(W)))); // R3
endmodule

// File: tb/sim_triplet_shift_finder.sv
module sim_triplet_shift_finder;
  localparam int N  = 16;
  localparam int W  = 3;
  localparam int LN = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hit_valid = 1'b0;
  logic [1:0]    plane = 2'd0;
  logic [LN-1:0] coord = '0;
  logic          start_match = 1'b0;
  logic          clear = 1'b0;
  logic          trip_valid, err_hit;
  logic [LN-1:0] trip_centre, trip_pos;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  triplet_shift_finder #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .plane(plane),
    .coord(coord), .start_match(start_match), .clear(clear),
    .trip_valid(trip_valid), .trip_centre(trip_centre),
    .trip_pos(trip_pos), .err_hit(err_hit));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void expect_for(input int b, input logic [N-1:0] ma,
                                     input logic [N-1:0] mc, output bit f, output int pos);
    f = 0;
    pos = 0;
    for (int i = 0; i <= 2 * W; i++) begin
      int a = b + i - W;
      int c = 2 * b - a;
      if (!f && a >= 0 && a < N && c >= 0 && c < N && ma[a] && mc[c]) begin
        f = 1;
        pos = a;
      end
    end
  endfunction

  task automatic put_hit(input logic [1:0] pl, input int c);
    hit_valid = 1'b1;
    plane = pl;
    coord = LN'(c);
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic pulse_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic pulse_start();
    start_match = 1'b1;
    @(negedge clk);
    start_match = 1'b0;
  endtask

  task automatic load_event(input logic [N-1:0] ma, input logic [N-1:0] mc, input bit junk);
    pulse_clear();
    for (int k = 0; k < N; k++) begin
      int x = (k * 5 + 3) % N;
      if (ma[x]) put_hit(2'd0, x);
      if (mc[x]) put_hit(2'd2, x);
      if (junk) begin
        put_hit(2'd1, x);
        put_hit(2'd3, (x + 7) % N);
      end
      check(err_hit == 1'b0, "R2 no error in fill phase", err_hit, 0);
    end
    pulse_start();
  endtask

  task automatic sweep(input logic [N-1:0] ma, input logic [N-1:0] mc);
    for (int j = 0; j < N + LN + 1; j++) begin
      int k = j - 1 - LN;
      if (k >= 0 && k < N) begin
        bit f;
        int pos;
        expect_for(k, ma, mc, f, pos);
        check(trip_valid == f, "R3 R5 trip_valid", trip_valid, f);
        if (f) begin
          check(trip_pos == LN'(pos), "R4 trip_pos", trip_pos, pos);
          check(trip_centre == LN'(k), "R4 trip_centre", trip_centre, k);
        end
      end
      if (j < N) begin
        hit_valid = 1'b1;
        plane = 2'd1;
        coord = LN'(j);
      end else begin
        hit_valid = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [N-1:0] lfsr(input logic [N-1:0] v);
    return {v[N-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] ra, rc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(trip_valid == 1'b0, "R1 trip_valid after reset", trip_valid, 0);
    check(err_hit == 1'b0, "R1 err_hit after reset", err_hit, 0);
    pulse_start();
    sweep('0, '0);

    // R1: arrays start empty; R3: a full array matches everywhere
    load_event('1, '1, 1'b0);
    sweep('1, '1);
    load_event(16'h0001, 16'h0001, 1'b0);
    sweep(16'h0001, 16'h0001);
    load_event(16'h8000, 16'h8000, 1'b0);
    sweep(16'h8000, 16'h8000);
    load_event(16'h0001, 16'h4000, 1'b0);
    sweep(16'h0001, 16'h4000);

    ra = 16'hACE1;
    rc = 16'h1D2B;
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 5; s++) begin
        ra = lfsr(ra);
        rc = lfsr(rc);
      end
      // R2: plane 1 and plane 3 junk during fill must not change the arrays
      load_event(ra & lfsr(ra), rc | lfsr(rc), e[0]);
      sweep(ra & lfsr(ra), rc | lfsr(rc));
    end

    // R6: an outer hit in the match phase is flagged and not stored
    load_event(16'h0000, 16'h0010, 1'b0);
    put_hit(2'd0, 10);
    check(err_hit == 1'b1, "R6 err_hit after outer hit in match", err_hit, 1);
    @(negedge clk);
    check(err_hit == 1'b0, "R6 err_hit is one cycle", err_hit, 0);
    put_hit(2'd2, 9);
    check(err_hit == 1'b1, "R6 err_hit for plane C hit", err_hit, 1);
    sweep(16'h0000, 16'h0010);

    // R7: clear wins over start_match and over an outer hit in the same cycle
    clear = 1'b1;
    start_match = 1'b1;
    hit_valid = 1'b1;
    plane = 2'd0;
    coord = LN'(10);
    @(negedge clk);
    clear = 1'b0;
    start_match = 1'b0;
    hit_valid = 1'b0;
    check(err_hit == 1'b0, "R7 no error when clear wins", err_hit, 0);
    put_hit(2'd2, 4);
    check(err_hit == 1'b0, "R7 fill phase after clear", err_hit, 0);
    for (int j = 0; j < N; j++) put_hit(2'd1, j);
    for (int j = 0; j < LN + 2; j++) begin
      check(trip_valid == 1'b0, "R2 centre hit ignored in fill phase", trip_valid, 0);
      @(negedge clk);
    end
    put_hit(2'd0, 10);
    pulse_start();
    // R3: a=10, c=4, b=7 sits exactly at |a-b| = W
    sweep(16'h0400, 16'h0010);

    // R3: a=11, c=3, b=7 is one step outside the window
    load_event(16'h0800, 16'h0008, 1'b0);
    sweep(16'h0800, 16'h0008);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule